// File: doc/BRIEF.md
# Programmable-Priority Interrupt Vector Selector

This block picks one interrupt to present to the processor for each of two delivery classes: a fast class and a normal class. Every request line has a routing bit that places it in one of the two classes. Every request line also has a two-bit priority level, which software sets through a small word-wide register port. On each clock, the block takes the pending lines of each class and finds the one with the most urgent level. When several lines share that level, the line with the larger index wins. The winner's index is registered, together with a valid flag for that class.

Vector generation has a global enable. While it is low, both valid flags and both vectors are held at zero. The register port takes writes on the clock edge on which they are presented, and it returns the addressed word combinationally. Each priority word packs the levels of a run of consecutive sources, two bits per source.

Top module: `irq_prio_select`

## Requirements
- R1: After reset every priority level is 00, so both priority words read back as zero.
- R2: The level encodings rank as follows: 00 (most urgent), then 01, then 10, then 11 (least urgent). A pending source at a more urgent level beats any pending source at a less urgent level in the same class.
- R3: Source k's level sits in priority word k/16, at bits [2*(k%16)+1 : 2*(k%16)]. Word 0 holds sources 0 to 15 and word 1 holds sources 16 to 31.
- R4: Among pending sources of one class that share the most urgent level present, the source with the highest index wins.
- R5: A routing bit of 1 puts the source in the fast class and 0 puts it in the normal class. Each class vector is computed only from the pending sources of that class.
- R6: A class with no pending source outputs valid 0 and vector 0.
- R7: While the generation enable is low, both valid flags and both vectors are 0 one cycle later, whatever is pending.
- R8: The outputs are registered. They reflect the pending, routing and enable inputs as sampled on the previous rising clock edge, and they update on every edge with no handshake.
- R9: A register write takes effect on the edge on which it is presented. A read returns the addressed word combinationally. Arbitration starts using the new level on the following edge.
- R10: The level of a source applies in whichever class its routing bit selects. Moving the source to the other class does not change its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| genEnable | input | 1 | Vector generation enable |
| reqPending | input | 32 | Pending request lines, one per source |
| routeFast | input | 32 | Class routing per source: 1 = fast, 0 = normal |
| regWrEn | input | 1 | Priority register write strobe |
| regAddr | input | 1 | Priority word address |
| regWrData | input | 32 | Priority word write data |
| regRdData | output | 32 | Addressed priority word, combinational |
| fastVec | output | 5 | Winning fast-class source index |
| fastValid | output | 1 | A fast-class source is pending |
| normVec | output | 5 | Winning normal-class source index |
| normValid | output | 1 | A normal-class source is pending |

## Verification
The bench builds the block with its default parameters: 32 sources, 2-bit levels and 32-bit words, which gives two priority words. With two words, the field packing at both ends of each word can be checked, including source 0, source 15, source 16 and source 31. Ties that cross the word boundary can also be checked. The full index range of the 5-bit vector is reachable, so the highest-index tie-break is exercised at index 31 as well as at low indices.

// File: rtl/prio_sel_pkg.sv
package prio_sel_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrStrobe;   // accepted write to an existing priority word
    logic vecLoad;    // capture arbitration results this edge
    logic vecClear;   // force outputs to zero this edge
  } selCtrl_t;

  typedef enum logic [1:0] {
    LVL_TOP  = 2'b00,
    LVL_UPPER = 2'b01,
    LVL_LOWER = 2'b10,
    LVL_BOTTOM = 2'b11
  } prioLevel_t;

endpackage

// File: rtl/prio_sel_ctrl.sv
module prio_sel_ctrl
  import prio_sel_pkg::*;
#(
  parameter int NUM_REGS = 2,
  parameter int ADDR_W   = 1
) (
  input  logic              genEnable,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output selCtrl_t          ctrl
);

  logic addrHit;

  always_comb begin
    addrHit       = (int'(regAddr) < NUM_REGS);
    ctrl.wrStrobe = regWrEn && addrHit;
    ctrl.vecLoad  = genEnable;
    ctrl.vecClear = !genEnable;
  end

endmodule

// File: rtl/prio_arbiter.sv
module prio_arbiter #(
  parameter int NUM_SRC = 32,
  parameter int FIELD_W = 2,
  parameter int IDX_W   = 5
) (
  input  logic [NUM_SRC-1:0]         pending,
  input  logic [NUM_SRC*FIELD_W-1:0] levels,
  output logic                       found,
  output logic [IDX_W-1:0]           winIdx
);

  // Ascending scan: "<=" lets a later (higher) index take over a tie.
  logic [FIELD_W-1:0] bestLvl;

  always_comb begin
    found   = 1'b0;
    winIdx  = '0;
    bestLvl = '1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && (!found || levels[i*FIELD_W +: FIELD_W] <= bestLvl)) begin
        found   = 1'b1;
        winIdx  = IDX_W'(i);
        bestLvl = levels[i*FIELD_W +: FIELD_W];
      end
    end
  end

endmodule

// File: rtl/prio_sel_datapath.sv
module prio_sel_datapath
  import prio_sel_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int FIELD_W  = 2,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 2,
  parameter int ADDR_W   = 1,
  parameter int IDX_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  selCtrl_t          ctrl,
  input  logic [NUM_SRC-1:0] reqPending,
  input  logic [NUM_SRC-1:0] routeFast,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [IDX_W-1:0]  fastVec,
  output logic              fastValid,
  output logic [IDX_W-1:0]  normVec,
  output logic              normValid
);

  localparam int STORE_W = NUM_REGS * DATA_W;
  localparam int NUM_CLS = 2;   // class 0 = fast, class 1 = normal

  logic [STORE_W-1:0]           prioStore;
  logic [NUM_SRC*FIELD_W-1:0]   srcLevels;
  logic [NUM_SRC-1:0]           clsMask  [NUM_CLS];
  logic                         clsFound [NUM_CLS];
  logic [IDX_W-1:0]             clsIdx   [NUM_CLS];

  // Priority word storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prioStore <= '0;
    end else if (ctrl.wrStrobe) begin
      prioStore[int'(regAddr)*DATA_W +: DATA_W] <= regWrData;
    end
  end

  always_comb begin
    if (int'(regAddr) < NUM_REGS) regRdData = prioStore[int'(regAddr)*DATA_W +: DATA_W];
    else                          regRdData = '0;
  end

  // Per-source level extraction
  genvar k;
  generate
    for (k = 0; k < NUM_SRC; k++) begin : g_lvl
      assign srcLevels[k*FIELD_W +: FIELD_W] = prioStore[k*FIELD_W +: FIELD_W];
    end
  endgenerate

  // One arbiter per class
  genvar c;
  generate
    for (c = 0; c < NUM_CLS; c++) begin : g_cls
      if (c == 0) begin : g_fast
        assign clsMask[c] = reqPending & routeFast;
      end else begin : g_norm
        assign clsMask[c] = reqPending & ~routeFast;
      end
      prio_arbiter #(
        .NUM_SRC (NUM_SRC),
        .FIELD_W (FIELD_W),
        .IDX_W   (IDX_W)
      ) u_arb (
        .pending (clsMask[c]),
        .levels  (srcLevels),
        .found   (clsFound[c]),
        .winIdx  (clsIdx[c])
      );
    end
  endgenerate

  // Registered vector outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fastValid <= 1'b0;
      fastVec   <= '0;
      normValid <= 1'b0;
      normVec   <= '0;
    end else if (ctrl.vecClear) begin
      fastValid <= 1'b0;
      fastVec   <= '0;
      normValid <= 1'b0;
      normVec   <= '0;
    end else if (ctrl.vecLoad) begin
      fastValid <= clsFound[0];
      fastVec   <= clsFound[0] ? clsIdx[0] : '0;
      normValid <= clsFound[1];
      normVec   <= clsFound[1] ? clsIdx[1] : '0;
    end
  end

  // Assertions
  assert_rdback_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ctrl.wrStrobe) && (regAddr == $past(regAddr))) |-> (regRdData == $past(regWrData)));

  assert_off_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.vecClear) |-> (!fastValid && !normValid && fastVec == '0 && normVec == '0));

  assert_fast_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.vecLoad) |-> (fastValid == $past(|(reqPending & routeFast))));

  assert_norm_valid_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrl.vecLoad) |-> (normValid == $past(|(reqPending & ~routeFast))));

  assert_class_split_R5: assert property (@(posedge clk) disable iff (!rstN)
    (fastValid && normValid) |-> (fastVec != normVec));

  assert_empty_vec_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!fastValid |-> fastVec == '0) and (!normValid |-> normVec == '0));

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select
  import prio_sel_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int FIELD_W = 2,
  parameter int DATA_W  = 32,
  localparam int SRC_PER_REG = DATA_W / FIELD_W,
  localparam int NUM_REGS    = (NUM_SRC + SRC_PER_REG - 1) / SRC_PER_REG,
  localparam int ADDR_W      = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int IDX_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               genEnable,
  input  logic [NUM_SRC-1:0] reqPending,
  input  logic [NUM_SRC-1:0] routeFast,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic [IDX_W-1:0]   fastVec,
  output logic               fastValid,
  output logic [IDX_W-1:0]   normVec,
  output logic               normValid
);

  selCtrl_t ctrl;

  prio_sel_ctrl #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .genEnable (genEnable),
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .ctrl      (ctrl)
  );

  prio_sel_datapath #(
    .NUM_SRC  (NUM_SRC),
    .FIELD_W  (FIELD_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .reqPending (reqPending),
    .routeFast  (routeFast),
    .regAddr    (regAddr),
    .regWrData  (regWrData),
    .regRdData  (regRdData),
    .fastVec    (fastVec),
    .fastValid  (fastValid),
    .normVec    (normVec),
    .normValid  (normValid)
  );

endmodule

// File: tb/irq_prio_select_tb.sv
module irq_prio_select_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        genEnable = 1'b1;
  logic [31:0] reqPending = '0;
  logic [31:0] routeFast = '0;
  logic        regWrEn = 1'b0;
  logic [0:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [4:0]  fastVec;
  logic        fastValid;
  logic [4:0]  normVec;
  logic        normValid;

  int checks = 0;
  int errors = 0;
  logic [63:0] shadow = '0;   // bench copy of the written levels

  always #5 clk = ~clk;

  irq_prio_select u_dut (
    .clk (clk), .rstN (rstN), .genEnable (genEnable),
    .reqPending (reqPending), .routeFast (routeFast),
    .regWrEn (regWrEn), .regAddr (regAddr), .regWrData (regWrData),
    .regRdData (regRdData), .fastVec (fastVec), .fastValid (fastValid),
    .normVec (normVec), .normValid (normValid)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference winner from the requirements: {valid, index}
  function automatic logic [5:0] pick(input logic [31:0] m);
    logic found = 1'b0;
    logic [1:0] best = 2'b11;
    logic [4:0] idx = '0;
    for (int i = 0; i < 32; i++) begin
      if (m[i] && (!found || shadow[2*i +: 2] <= best)) begin
        found = 1'b1; best = shadow[2*i +: 2]; idx = 5'(i);
      end
    end
    return {found, idx};
  endfunction

  task automatic writeReg(input int a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    shadow[a*32 +: 32] = d;
  endtask

  task automatic expectOut(input string req, input logic fv, input logic [4:0] fi,
                           input logic nv, input logic [4:0] ni);
    check({req, " fastValid"}, 32'(fastValid), 32'(fv));
    check({req, " fastVec"},   32'(fastVec),   32'(fi));
    check({req, " normValid"}, 32'(normValid), 32'(nv));
    check({req, " normVec"},   32'(normVec),   32'(ni));
  endtask

  task automatic applyCheck(input string req, input logic [31:0] p, input logic [31:0] r);
    logic [5:0] ef, en;
    @(negedge clk);
    reqPending = p; routeFast = r;
    @(negedge clk);
    ef = pick(p & r);
    en = pick(p & ~r);
    expectOut(req, ef[5], ef[4:0], en[5], en[4:0]);
  endtask

  task automatic resetTest();
    regAddr = 1'b0; #1;
    check("R1 word0 reset", regRdData, 32'h0);
    regAddr = 1'b1; #1;
    check("R1 word1 reset", regRdData, 32'h0);
    expectOut("R6 reset outputs", 1'b0, 5'd0, 1'b0, 5'd0);
    applyCheck("R1 all-00 tie", 32'h0000_0F0F, 32'hFFFF_FFFF);
    check("R1 winner 11", 32'(fastVec), 32'd11);
  endtask

  task automatic tieTest();
    applyCheck("R4 tie 31", 32'h8000_0001, 32'h0);
    check("R4 normVec 31", 32'(normVec), 32'd31);
    applyCheck("R4 tie 2", 32'h0000_0006, 32'h0);
    check("R4 normVec 2", 32'(normVec), 32'd2);
    applyCheck("R4 tie across words", 32'h0001_8000, 32'hFFFF_FFFF);
    check("R4 fastVec 16", 32'(fastVec), 32'd16);
  endtask

  task automatic levelTest();
    // all 01, then src5=00, src20=10, src30=11
    writeReg(0, 32'h5555_5155);
    writeReg(1, 32'h7555_5655);
    applyCheck("R2 00 beats all", (1 << 5) | (1 << 20) | (1 << 30) | (1 << 7), 32'hFFFF_FFFF);
    check("R2 fastVec 5", 32'(fastVec), 32'd5);
    applyCheck("R2 01 beats 10", (1 << 20) | (1 << 30) | (1 << 7), 32'hFFFF_FFFF);
    check("R2 fastVec 7", 32'(fastVec), 32'd7);
    applyCheck("R2 10 beats 11", (1 << 20) | (1 << 30), 32'hFFFF_FFFF);
    check("R2 fastVec 20", 32'(fastVec), 32'd20);
    for (int n = 0; n < 6; n++)
      applyCheck("R2 mixed", 32'hA5C3_1E69 ^ (32'h1357_9BDF * 32'(n)), 32'h0F0F_33CC ^ (32'(n) << 3));
  endtask

  task automatic layoutTest();
    writeReg(0, 32'hFFFF_FFFC);   // src0 = 00
    writeReg(1, 32'hFFFF_FFFC);   // src16 = 00
    applyCheck("R3 src0 field", 32'h0000_8001, 32'h0);
    check("R3 normVec 0", 32'(normVec), 32'd0);
    applyCheck("R3 src16 field", 32'h8001_0000, 32'h0);
    check("R3 normVec 16", 32'(normVec), 32'd16);
    writeReg(0, 32'h3FFF_FFFF);   // src15 = 00
    writeReg(1, 32'h3FFF_FFFF);   // src31 = 00
    applyCheck("R3 src31 field", 32'h8001_4000, 32'h0);
    check("R3 normVec 31", 32'(normVec), 32'd31);
    applyCheck("R3 src15 field", 32'h0001_8001, 32'h0);
    check("R3 normVec 15", 32'(normVec), 32'd15);
  endtask

  task automatic splitTest();
    writeReg(0, 32'hFFFF_FCFF);   // src4 = 00
    writeReg(1, 32'hFFFF_FFFF);
    applyCheck("R5 split", (1 << 4) | (1 << 9) | (1 << 20), 1 << 9);
    expectOut("R5 split vals", 1'b1, 5'd9, 1'b1, 5'd4);
    applyCheck("R10 level follows source", (1 << 4) | (1 << 9) | (1 << 20), 1 << 4);
    expectOut("R10 moved vals", 1'b1, 5'd4, 1'b1, 5'd20);
  endtask

  task automatic emptyTest();
    applyCheck("R6 normal empty", 32'h0000_0300, 32'hFFFF_FFFF);
    expectOut("R6 normal empty vals", 1'b1, 5'd9, 1'b0, 5'd0);
    applyCheck("R6 both empty", 32'h0, 32'h0);
    expectOut("R6 both empty vals", 1'b0, 5'd0, 1'b0, 5'd0);
  endtask

  task automatic disableTest();
    @(negedge clk);
    reqPending = 32'hF0F0_F0F0; routeFast = 32'h00FF_00FF; genEnable = 1'b0;
    @(negedge clk);
    expectOut("R7 disabled", 1'b0, 5'd0, 1'b0, 5'd0);
    @(negedge clk);
    genEnable = 1'b1;
    @(negedge clk);
    check("R7 re-enabled fastValid", 32'(fastValid), 32'd1);
    check("R7 re-enabled normValid", 32'(normValid), 32'd1);
  endtask

  task automatic latencyTest();
    writeReg(0, 32'h0);
    writeReg(1, 32'h0);
    applyCheck("R8 base", 1 << 3, 32'hFFFF_FFFF);
    @(negedge clk);
    reqPending = 1 << 12;
    #1;
    check("R8 holds before edge", 32'(fastVec), 32'd3);
    @(negedge clk);
    check("R8 after edge", 32'(fastVec), 32'd12);
  endtask

  task automatic writeTimingTest();
    writeReg(0, 32'h5555_5555);
    writeReg(1, 32'h5555_5555);
    applyCheck("R9 base", (1 << 3) | (1 << 10), 32'hFFFF_FFFF);
    check("R9 base winner", 32'(fastVec), 32'd10);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b0; regWrData = 32'h5555_5515;   // src3 = 00
    @(negedge clk);
    regWrEn = 1'b0; shadow[31:0] = 32'h5555_5515;
    check("R9 read after edge", regRdData, 32'h5555_5515);
    check("R9 old level used", 32'(fastVec), 32'd10);
    @(negedge clk);
    check("R9 new level used", 32'(fastVec), 32'd3);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    resetTest();
    tieTest();
    levelTest();
    layoutTest();
    splitTest();
    emptyTest();
    disableTest();
    latencyTest();
    writeTimingTest();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule